// File: doc/BRIEF.md
# Serial Flash Controller Register Bank

This block is the software-visible register bank of a serial-flash interface unit. It holds 32-bit words on a simple word-access bus with byte address, write enable, write data and read data. Reads are combinational. Writes commit on the rising clock edge.

The bank stores the configuration for memory-mapped flash reads and writes, the user-mode transfer setup, a control/status word, an opcode word, an address word and four outgoing data words. It also holds a protection setup word, ten protection opcode words and a global setup word. Four incoming data words are filled only by the transfer engine.

The configuration words can lock themselves, either as a whole or in selected fields. The ready flag in the control/status word clears when software writes one to it. The start bit can be set by software but is cleared only when the engine reports that the transfer is complete.

The bank drives the stored setup to the engines as plain outputs. It raises a one-cycle start pulse when a user-mode transfer is launched. From the engine it accepts completion and read-data updates.

Top module: `flash_ctl_regs`

## Requirements
- R1: A synchronous active-high reset loads these words:
  - direct-read setup (0x00) = 0x0300100B
  - direct-write setup (0x04) = 0x03000002
  - user setup (0x08) = 0x00000400
  - control/status (0x0C) = 0x00010000
  - opcode (0x10) = 0x0000000B
  - protection setup (0x18) = 0x00000400
  - global setup (0x78) = 0x0000000B
  - every other word = 0
- R2: These words read back exactly what was last written: opcode 0x10, address 0x14, protection setup 0x18, outgoing data 0x20–0x2C, protection opcodes 0x40–0x64 and global setup 0x78. An access whose byte address has bits [1:0] nonzero, or whose offset is unmapped (for example 0x1C or 0x68), reads 0 and leaves all state unchanged when written.
- R3: A write to 0x00, 0x04 or 0x08 is dropped entirely while the word currently stored there has bit 31 set.
- R4: While the stored user setup (0x08) has bit 30 set and bit 31 clear, a write to 0x08 keeps the old values of bits 10, 1 and 0 (mask 0x00000403) and takes all other bits from the write data.
- R5: In control/status (0x0C), writing 1 to bit 24 (ready) clears it, and writing 0 to it leaves it unchanged. Bits other than 0 and 24 are plain read/write.
- R6: Writing 1 to control/status bit 0 while it is 0 sets it and raises start_o for exactly the cycle in which bit 0 first reads 1. Writing 0 to bit 0 never clears it. Writing 1 while it is already 1 gives no new pulse.
- R7: When eng_done is high for one cycle, the next cycle shows control/status bit 24 = 1 and bit 0 = 0. This holds even if a write of 1 to bit 24 lands in the same cycle. If a write of 1 to bit 0 lands in the same cycle as eng_done, a new transfer starts: bit 0 reads 1 and start_o pulses.
- R8: The incoming data words at 0x30–0x3C ignore bus writes. Word eng_rd_sel (0 to 3) takes eng_rd_data on a cycle with eng_rd_we high.
- R9: The outputs cfg_rd_o, cfg_wr_o, cfg_usr_o, ctl_o, cmd_o, addr_o and wdata_o always equal the stored words. wdata_o holds word 0x20 in bits [31:0] up to word 0x2C in bits [127:96].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| eng_done | input | 1 | User-mode transfer complete |
| eng_rd_we | input | 1 | Engine write to an incoming data word |
| eng_rd_sel | input | 2 | Incoming data word index |
| eng_rd_data | input | 32 | Incoming data value |
| start_o | output | 1 | One-cycle transfer launch pulse |
| cfg_rd_o | output | 32 | Direct-read setup |
| cfg_wr_o | output | 32 | Direct-write setup |
| cfg_usr_o | output | 32 | User-mode setup |
| ctl_o | output | 32 | Control/status word |
| cmd_o | output | 32 | Opcode word |
| addr_o | output | 32 | Address word |
| wdata_o | output | 128 | Four outgoing data words |

## Verification
The checker property-checks the following on every cycle:
- a locked configuration word stays frozen across a write;
- the field-protected bits of the user setup hold their values;
- a write of one to the ready flag clears it when no completion is in the same cycle;
- the start bit stays set until completion;
- completion always leaves the ready flag set;
- the start pulse coincides with the stored start bit.

Only the bench scenarios show the following:
- the exact reset contents and the register map;
- that misaligned and unmapped accesses are inert;
- that the incoming data words cannot be written from the bus;
- the same-cycle collisions of completion with a new start and with a ready clear.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned N_WD     = 4;
    localparam int unsigned N_RD     = 4;
    localparam int unsigned N_PCMD   = 10;
    localparam int unsigned SUB_W    = 4;

    // word indices (byte offset / 4); the map itself is behaviour
    localparam int unsigned W_DRD    = 0;
    localparam int unsigned W_DWR    = 1;
    localparam int unsigned W_USR    = 2;
    localparam int unsigned W_CTL    = 3;
    localparam int unsigned W_CMD    = 4;
    localparam int unsigned W_ADR    = 5;
    localparam int unsigned W_PCFG   = 6;
    localparam int unsigned W_WD0    = 8;
    localparam int unsigned W_RD0    = W_WD0 + N_WD;
    localparam int unsigned W_PCMD0  = 16;
    localparam int unsigned W_GCFG   = 30;

    // control bits
    localparam int unsigned LOCK_BIT   = 31;
    localparam int unsigned FLOCK_BIT  = 30;
    localparam logic [DATA_W-1:0] FLOCK_MASK = 32'h0000_0403;
    localparam int unsigned BUSY_BIT   = 0;
    localparam int unsigned READY_BIT  = 24;

    // reset contents
    localparam logic [DATA_W-1:0] RST_DRD  = 32'h0300_100B;
    localparam logic [DATA_W-1:0] RST_DWR  = 32'h0300_0002;
    localparam logic [DATA_W-1:0] RST_USR  = 32'h0000_0400;
    localparam logic [DATA_W-1:0] RST_CTL  = 32'h0001_0000;
    localparam logic [DATA_W-1:0] RST_CMD  = 32'h0000_000B;
    localparam logic [DATA_W-1:0] RST_PCFG = 32'h0000_0400;
    localparam logic [DATA_W-1:0] RST_GCFG = 32'h0000_000B;

    typedef enum logic [3:0] {
        K_DRD, K_DWR, K_USR, K_CTL, K_CMD, K_ADR, K_PCFG,
        K_WD, K_RD, K_PCMD, K_GCFG, K_NONE
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [SUB_W-1:0] sub;
    } dec_t;

    function automatic dec_t decode(input logic [15:0] widx);
        dec_t d;
        d.kind = K_NONE;
        d.sub  = '0;
        if (widx == 16'(W_DRD))       d.kind = K_DRD;
        else if (widx == 16'(W_DWR))  d.kind = K_DWR;
        else if (widx == 16'(W_USR))  d.kind = K_USR;
        else if (widx == 16'(W_CTL))  d.kind = K_CTL;
        else if (widx == 16'(W_CMD))  d.kind = K_CMD;
        else if (widx == 16'(W_ADR))  d.kind = K_ADR;
        else if (widx == 16'(W_PCFG)) d.kind = K_PCFG;
        else if (widx == 16'(W_GCFG)) d.kind = K_GCFG;
        else if (widx >= 16'(W_WD0) && widx < 16'(W_WD0 + N_WD)) begin
            d.kind = K_WD;
            d.sub  = SUB_W'(widx - 16'(W_WD0));
        end else if (widx >= 16'(W_RD0) && widx < 16'(W_RD0 + N_RD)) begin
            d.kind = K_RD;
            d.sub  = SUB_W'(widx - 16'(W_RD0));
        end else if (widx >= 16'(W_PCMD0) && widx < 16'(W_PCMD0 + N_PCMD)) begin
            d.kind = K_PCMD;
            d.sub  = SUB_W'(widx - 16'(W_PCMD0));
        end
        return d;
    endfunction

endpackage

// File: rtl/fcr_lock_reg.sv
module fcr_lock_reg
    import fcr_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL    = '0,
    parameter bit                FIELD_LOCK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] merged;

    generate
        if (FIELD_LOCK) begin : g_flock
            always_comb begin
                if (q[FLOCK_BIT])
                    merged = (wr_data & ~FLOCK_MASK) | (q & FLOCK_MASK);
                else
                    merged = wr_data;
            end
        end else begin : g_plain
            always_comb merged = wr_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (wr_en && !q[LOCK_BIT])
            q <= merged;
    end

endmodule

// File: rtl/fcr_ctrl_stat.sv
module fcr_ctrl_stat
    import fcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_done,
    output logic [DATA_W-1:0] q,
    output logic              start_o
);

    logic              launch;
    logic [DATA_W-1:0] nxt;

    assign launch = wr_en && wr_data[BUSY_BIT] && (!q[BUSY_BIT] || eng_done);

    always_comb begin
        nxt = wr_en ? wr_data : q;
        // ready: engine completion beats a software clear
        if (eng_done)
            nxt[READY_BIT] = 1'b1;
        else if (wr_en && wr_data[READY_BIT])
            nxt[READY_BIT] = 1'b0;
        else
            nxt[READY_BIT] = q[READY_BIT];
        // busy: only software start sets, only completion clears
        if (launch)
            nxt[BUSY_BIT] = 1'b1;
        else if (eng_done)
            nxt[BUSY_BIT] = 1'b0;
        else
            nxt[BUSY_BIT] = q[BUSY_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= RST_CTL;
            start_o <= 1'b0;
        end else begin
            q       <= nxt;
            start_o <= launch;
        end
    end

endmodule

// File: rtl/fcr_word_bank.sv
module fcr_word_bank
    import fcr_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N-1:0]               wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [N-1:0][DATA_W-1:0]   q
);

    for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (wr_en[i])
                q[i] <= wr_data;
        end
    end

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import fcr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic                     eng_done,
    input  logic                     eng_rd_we,
    input  logic [1:0]               eng_rd_sel,
    input  logic [31:0]              eng_rd_data,
    output logic                     start_o,
    output logic [31:0]              cfg_rd_o,
    output logic [31:0]              cfg_wr_o,
    output logic [31:0]              cfg_usr_o,
    output logic [31:0]              ctl_o,
    output logic [31:0]              cmd_o,
    output logic [31:0]              addr_o,
    output logic [127:0]             wdata_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             aligned;
    logic             wr;
    dec_t             dec;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_we && aligned;
    assign dec     = decode(16'(widx));

    // plain single words
    logic [DATA_W-1:0] cmd_q, adr_q, pcfg_q, gcfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= RST_CMD;
            adr_q  <= '0;
            pcfg_q <= RST_PCFG;
            gcfg_q <= RST_GCFG;
        end else if (wr) begin
            if (dec.kind == K_CMD)  cmd_q  <= bus_wdata;
            if (dec.kind == K_ADR)  adr_q  <= bus_wdata;
            if (dec.kind == K_PCFG) pcfg_q <= bus_wdata;
            if (dec.kind == K_GCFG) gcfg_q <= bus_wdata;
        end
    end

    // lockable configuration words
    logic [DATA_W-1:0] drd_q, dwr_q, usr_q;

    fcr_lock_reg #(.RST_VAL(RST_DRD), .FIELD_LOCK(1'b0)) u_drd (
        .clk(clk), .rst(rst), .wr_en(wr && dec.kind == K_DRD),
        .wr_data(bus_wdata), .q(drd_q));

    fcr_lock_reg #(.RST_VAL(RST_DWR), .FIELD_LOCK(1'b0)) u_dwr (
        .clk(clk), .rst(rst), .wr_en(wr && dec.kind == K_DWR),
        .wr_data(bus_wdata), .q(dwr_q));

    fcr_lock_reg #(.RST_VAL(RST_USR), .FIELD_LOCK(1'b1)) u_usr (
        .clk(clk), .rst(rst), .wr_en(wr && dec.kind == K_USR),
        .wr_data(bus_wdata), .q(usr_q));

    // control / status
    logic [DATA_W-1:0] ctl_q;

    fcr_ctrl_stat u_ctl (
        .clk(clk), .rst(rst), .wr_en(wr && dec.kind == K_CTL),
        .wr_data(bus_wdata), .eng_done(eng_done),
        .q(ctl_q), .start_o(start_o));

    // word banks
    logic [N_WD-1:0]                 wd_we;
    logic [N_RD-1:0]                 rd_we;
    logic [N_PCMD-1:0]               pcmd_we;
    logic [N_WD-1:0][DATA_W-1:0]     wd_q;
    logic [N_RD-1:0][DATA_W-1:0]     rd_q;
    logic [N_PCMD-1:0][DATA_W-1:0]   pcmd_q;

    always_comb begin
        for (int i = 0; i < N_WD; i++)
            wd_we[i] = wr && dec.kind == K_WD && dec.sub == SUB_W'(i);
        for (int i = 0; i < N_RD; i++)
            rd_we[i] = eng_rd_we && eng_rd_sel == 2'(i);
        for (int i = 0; i < N_PCMD; i++)
            pcmd_we[i] = wr && dec.kind == K_PCMD && dec.sub == SUB_W'(i);
    end

    fcr_word_bank #(.N(N_WD)) u_wd (
        .clk(clk), .rst(rst), .wr_en(wd_we), .wr_data(bus_wdata), .q(wd_q));

    fcr_word_bank #(.N(N_RD)) u_rd (
        .clk(clk), .rst(rst), .wr_en(rd_we), .wr_data(eng_rd_data), .q(rd_q));

    fcr_word_bank #(.N(N_PCMD)) u_pcmd (
        .clk(clk), .rst(rst), .wr_en(pcmd_we), .wr_data(bus_wdata), .q(pcmd_q));

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (dec.kind)
                K_DRD:  bus_rdata = drd_q;
                K_DWR:  bus_rdata = dwr_q;
                K_USR:  bus_rdata = usr_q;
                K_CTL:  bus_rdata = ctl_q;
                K_CMD:  bus_rdata = cmd_q;
                K_ADR:  bus_rdata = adr_q;
                K_PCFG: bus_rdata = pcfg_q;
                K_GCFG: bus_rdata = gcfg_q;
                K_WD:   bus_rdata = wd_q[dec.sub[1:0]];
                K_RD:   bus_rdata = rd_q[dec.sub[1:0]];
                K_PCMD: bus_rdata = pcmd_q[dec.sub];
                default: bus_rdata = '0;
            endcase
        end
    end

    assign cfg_rd_o  = drd_q;
    assign cfg_wr_o  = dwr_q;
    assign cfg_usr_o = usr_q;
    assign ctl_o     = ctl_q;
    assign cmd_o     = cmd_q;
    assign addr_o    = adr_q;
    assign wdata_o   = wd_q;

endmodule

// File: rtl/fcr_checker.sv
module fcr_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              eng_done,
    input logic              start_o,
    input logic [31:0]       cfg_rd_o,
    input logic [31:0]       cfg_usr_o,
    input logic [31:0]       ctl_o
);

    a_r1_ctl_reset: assert property (@(posedge clk)
        rst |=> (ctl_o == 32'h0001_0000 && !start_o));

    a_r3_lock_freeze: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(0) && cfg_rd_o[31]) |=> $stable(cfg_rd_o));

    a_r4_field_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(8) && !cfg_usr_o[31] && cfg_usr_o[30])
        |=> ((cfg_usr_o & 32'h0000_0403) == ($past(cfg_usr_o) & 32'h0000_0403)));

    a_r5_ready_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(12) && bus_wdata[24] && !eng_done) |=> !ctl_o[24]);

    a_r6_busy_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl_o[0] && !eng_done) |=> ctl_o[0]);

    a_r6_pulse_busy: assert property (@(posedge clk) disable iff (rst)
        start_o |-> ctl_o[0]);

    a_r7_done_ready: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> ctl_o[24]);

endmodule

bind flash_ctl_regs fcr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .eng_done(eng_done), .start_o(start_o),
    .cfg_rd_o(cfg_rd_o), .cfg_usr_o(cfg_usr_o), .ctl_o(ctl_o));

// File: tb/flash_ctl_regs_bench.sv
module flash_ctl_regs_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [11:0]  bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_done = 1'b0;
    logic         eng_rd_we = 1'b0;
    logic [1:0]   eng_rd_sel = '0;
    logic [31:0]  eng_rd_data = '0;
    logic         start_o;
    logic [31:0]  cfg_rd_o, cfg_wr_o, cfg_usr_o, ctl_o, cmd_o, addr_o;
    logic [127:0] wdata_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    flash_ctl_regs u_flash_ctl_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
        .eng_rd_we(eng_rd_we), .eng_rd_sel(eng_rd_sel), .eng_rd_data(eng_rd_data),
        .start_o(start_o), .cfg_rd_o(cfg_rd_o), .cfg_wr_o(cfg_wr_o),
        .cfg_usr_o(cfg_usr_o), .ctl_o(ctl_o), .cmd_o(cmd_o), .addr_o(addr_o),
        .wdata_o(wdata_o));

    typedef struct packed {
        logic [11:0] a;
        logic        we;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R1 reset contents
        '{12'h000, 1'b0, 32'h0, 32'h0300_100B},
        '{12'h004, 1'b0, 32'h0, 32'h0300_0002},
        '{12'h008, 1'b0, 32'h0, 32'h0000_0400},
        '{12'h00C, 1'b0, 32'h0, 32'h0001_0000},
        '{12'h010, 1'b0, 32'h0, 32'h0000_000B},
        '{12'h018, 1'b0, 32'h0, 32'h0000_0400},
        '{12'h078, 1'b0, 32'h0, 32'h0000_000B},
        '{12'h014, 1'b0, 32'h0, 32'h0000_0000},
        // R2 plain read/write words
        '{12'h010, 1'b1, 32'hA5A5_0001, 32'hA5A5_0001},
        '{12'h014, 1'b1, 32'h0012_3456, 32'h0012_3456},
        '{12'h020, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{12'h02C, 1'b1, 32'h0102_0304, 32'h0102_0304},
        '{12'h040, 1'b1, 32'h1111_1111, 32'h1111_1111},
        '{12'h064, 1'b1, 32'h9999_9999, 32'h9999_9999},
        '{12'h078, 1'b1, 32'h8000_0055, 32'h8000_0055},
        '{12'h018, 1'b1, 32'h1234_0000, 32'h1234_0000},
        // R8 incoming words ignore bus writes
        '{12'h030, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        // R2 unmapped and misaligned
        '{12'h01C, 1'b1, 32'h0000_0005, 32'h0000_0000},
        '{12'h068, 1'b1, 32'h0000_0077, 32'h0000_0000},
        '{12'h022, 1'b1, 32'h0000_0077, 32'h0000_0000},
        '{12'h020, 1'b0, 32'h0, 32'hDEAD_BEEF},
        '{12'h010, 1'b0, 32'h0, 32'hA5A5_0001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R9 outputs after reset
        chk("R9 cfg_rd_o reset", cfg_rd_o, 32'h0300_100B);
        chk("R9 cfg_wr_o reset", cfg_wr_o, 32'h0300_0002);
        chk("R1 start_o reset", {31'b0, start_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].a, VECS[i].d);
            rd(VECS[i].a, v);
            chk($sformatf("R2/R1/R8 vector %0d", i), v, VECS[i].exp);
        end
        chk("R9 wdata_o word0", wdata_o[31:0], 32'hDEAD_BEEF);
        chk("R9 wdata_o word3", wdata_o[127:96], 32'h0102_0304);
        chk("R9 cmd_o", cmd_o, 32'hA5A5_0001);
        chk("R9 addr_o", addr_o, 32'h0012_3456);

        // R8 engine fills incoming words
        @(negedge clk);
        eng_rd_we = 1'b1; eng_rd_sel = 2'd2; eng_rd_data = 32'hCAFE_F00D;
        @(negedge clk);
        eng_rd_we = 1'b0;
        rd(12'h038, v); chk("R8 engine write word2", v, 32'hCAFE_F00D);
        rd(12'h030, v); chk("R8 word0 untouched", v, 32'h0);

        // R3 whole-word lock
        wr(12'h000, 32'h8000_1234);
        rd(12'h000, v); chk("R3 lock write taken", v, 32'h8000_1234);
        wr(12'h000, 32'h0000_0000);
        rd(12'h000, v); chk("R3 locked drd", v, 32'h8000_1234);
        wr(12'h004, 32'h8000_0001);
        wr(12'h004, 32'h0000_00FF);
        rd(12'h004, v); chk("R3 locked dwr", v, 32'h8000_0001);

        // R4 field lock on user setup
        wr(12'h008, 32'h4000_0000);
        rd(12'h008, v); chk("R4 arm field lock", v, 32'h4000_0000);
        wr(12'h008, 32'h4000_0FFF);
        rd(12'h008, v); chk("R4 masked bits kept", v, 32'h4000_0BFC);
        wr(12'h008, 32'h8000_0403);
        rd(12'h008, v); chk("R4 mask with lock", v, 32'h8000_0000);
        wr(12'h008, 32'h0000_0000);
        rd(12'h008, v); chk("R3 locked usr", v, 32'h8000_0000);
        chk("R9 cfg_usr_o", cfg_usr_o, 32'h8000_0000);

        do_reset();
        rd(12'h000, v); chk("R1 lock cleared by reset", v, 32'h0300_100B);

        // R6 start and busy
        wr(12'h00C, 32'h0000_0001);
        chk("R6 start pulse", {31'b0, start_o}, 32'h1);
        rd(12'h00C, v); chk("R6 busy set", v, 32'h0000_0001);
        @(negedge clk);
        chk("R6 pulse one cycle", {31'b0, start_o}, 32'h0);
        wr(12'h00C, 32'h0000_0000);
        rd(12'h00C, v); chk("R6 busy not clearable", v, 32'h0000_0001);
        wr(12'h00C, 32'h0000_0001);
        chk("R6 no pulse while busy", {31'b0, start_o}, 32'h0);

        // R7 completion
        done_pulse();
        rd(12'h00C, v); chk("R7 done sets ready clears busy", v, 32'h0100_0000);

        // R5 ready write semantics
        wr(12'h00C, 32'h0000_0100);
        rd(12'h00C, v); chk("R5 write 0 keeps ready", v, 32'h0100_0100);
        wr(12'h00C, 32'h0100_0000);
        rd(12'h00C, v); chk("R5 write 1 clears ready", v, 32'h0000_0000);

        // R7 completion beats ready clear
        wr(12'h00C, 32'h0000_0001);
        @(negedge clk);
        bus_addr = 12'h00C; bus_wdata = 32'h0100_0000; bus_we = 1'b1; eng_done = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; eng_done = 1'b0;
        rd(12'h00C, v); chk("R7 done wins over clear", v, 32'h0100_0000);

        // R7 completion with new start in same cycle
        wr(12'h00C, 32'h0000_0001);
        @(negedge clk);
        bus_addr = 12'h00C; bus_wdata = 32'h0000_0001; bus_we = 1'b1; eng_done = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; eng_done = 1'b0;
        chk("R7 restart pulse", {31'b0, start_o}, 32'h1);
        rd(12'h00C, v); chk("R7 restart state", v, 32'h0100_0001);
        chk("R9 ctl_o", ctl_o, 32'h0100_0001);

        summary();
        $finish;
    end

endmodule